// File: doc/BRIEF.md
# Configurable Bidirectional Port Controller

This block drives one eight-pin general-purpose port. Three registers control it, and software writes each of them over a small register bus with a per-bit write mask. The data register holds the levels to drive. The direction register picks the drive style of each pin: push-pull drives both levels, and open-drain can only pull low. The function-select register routes either the data bit or a peripheral's special-function output to each pin. A fourth, read-only address returns the pin levels after a two-flop synchronizer.

For every pin the block produces an output enable, an output level and a weak pull-up enable. From reset, every pin is held weakly high. The pull-ups stay on until software first writes the function-select register, and after that they stay off until the next reset. A two-state sequencer records this:

- State `PU_WEAK` is entered on reset and drives every pull-up enable high.
- The transition `WEAK_TO_RELEASED` fires on any write to the function-select register.
- State `PU_RELEASED` drives every pull-up enable low. It has a single transition, `RELEASED_HOLD`, back to itself, so only reset leaves it.

Writing the function-select register has two further effects:

- A write that touches bit 2 pulses the set request for external interrupt 0.
- A write that touches bit 4 pulses the set request for external interrupt 1.

Pin 5 can also carry an active-low bus hold request. When that pin is configured for plain I/O, the hold output is held inactive.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the data register reads 0xFF (address 0), the direction register reads 0xFF (address 1) and the function-select register reads 0x00 (address 2). All pull-up enables are 1 and all output enables are 0.
- R2: Any write to address 2 sets all eight pull-up enables to 0 from the next clock edge, even with an all-zero write mask or a value equal to the reset value. They stay 0 until reset.
- R3: Writes to address 0 or address 1 leave the pull-up enables unchanged.
- R4: A pin whose direction bit is 0 is push-pull: its output enable is 1 and its output level equals the selected source bit.
- R5: A pin whose direction bit is 1 is open-drain. A selected source bit of 0 gives output enable 1 with output level 0. A selected source bit of 1 gives output enable 0 (high impedance).
- R6: A function-select bit of 1 makes the pin's selected source the special-function input bit. A function-select bit of 0 makes it the data register bit.
- R7: A write changes only the register bits whose write-mask bit is 1.
- R8: A write to address 2 with mask bit 2 set raises `int0_set` for exactly the one cycle after the write edge. With mask bit 4 set it raises `int1_set` in the same way. Other writes raise neither output.
- R9: `hold_req_n` is 1 while function-select bit 5 is 0, whatever the level on pin 5. While that bit is 1, `hold_req_n` follows pin 5 through the two-flop synchronizer.
- R10: Address 3 returns the pin levels two clock edges after they change, whatever the direction and function-select settings. Writes to address 3 have no effect on any register.
- R11: Writing direction 0x1F, then function-select 0x00, then data 0x93 gives output enables 0xEC and output levels 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 function select, 3 pin input |
| wdata | input | 8 | Write data |
| wbe | input | 8 | Per-bit write mask |
| rdata | output | 8 | Read data for `addr` |
| pin_in | input | 8 | Pad input levels |
| sf_out | input | 8 | Special-function output levels from peripherals |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| int0_set | output | 1 | One-cycle set request for external interrupt 0 pending flag |
| int1_set | output | 1 | One-cycle set request for external interrupt 1 pending flag |
| hold_req_n | output | 1 | Active-low hold request to the bus controller |

## Verification
The hardest situation to reach is the pull-up release caused by a function-select write that changes nothing: an all-zero mask, or a value equal to the reset value. Register read-back cannot show that such a write happened. The stimulus therefore resets the block and issues exactly that write. It then checks at the ports that all pull-ups drop, that the register still reads 0x00, and that no interrupt pulse appears. A second case writes the direction register and the data register before the function-select write. This proves that only the function-select write moves the sequencer out of `PU_WEAK`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_FSEL = 2'd2,
        REG_PINS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PU_WEAK     = 1'b0,
        PU_RELEASED = 1'b1
    } pu_state_e;

    function automatic logic [7:0] mask_merge(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int         W        = 8,
    parameter logic [7:0] DATA_RST = 8'hFF,
    parameter logic [7:0] DIR_RST  = 8'hFF,
    parameter logic [7:0] FSEL_RST = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wbe,
    input  logic [W-1:0] pins_sync,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] fsel_q,
    output logic [W-1:0] rdata,
    output logic         fsel_wr
);

    logic data_wr;
    logic dir_wr;

    always_comb begin
        data_wr = wr_en && (reg_sel_e'(addr) == REG_DATA);
        dir_wr  = wr_en && (reg_sel_e'(addr) == REG_DIR);
        fsel_wr = wr_en && (reg_sel_e'(addr) == REG_FSEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= DATA_RST[W-1:0];
            dir_q  <= DIR_RST[W-1:0];
            fsel_q <= FSEL_RST[W-1:0];
        end else begin
            if (data_wr) data_q <= (data_q & ~wbe) | (wdata & wbe);
            if (dir_wr)  dir_q  <= (dir_q  & ~wbe) | (wdata & wbe);
            if (fsel_wr) fsel_q <= (fsel_q & ~wbe) | (wdata & wbe);
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_DATA: rdata = data_q;
            REG_DIR:  rdata = dir_q;
            REG_FSEL: rdata = fsel_q;
            REG_PINS: rdata = pins_sync;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pullup_fsm.sv
module gpio_pullup_fsm
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fsel_wr,
    output logic [W-1:0] pu_en
);

    pu_state_e state_q;
    pu_state_e state_d;

    always_comb begin
        unique case (state_q)
            PU_WEAK:     state_d = fsel_wr ? PU_RELEASED : PU_WEAK;  // WEAK_TO_RELEASED
            PU_RELEASED: state_d = PU_RELEASED;                      // RELEASED_HOLD
            default:     state_d = PU_WEAK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PU_WEAK;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PU_WEAK:     pu_en = '1;
            PU_RELEASED: pu_en = '0;
            default:     pu_en = '1;
        endcase
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] fsel_q,
    input  logic [W-1:0] sf_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic src;
        always_comb begin
            src = fsel_q[i] ? sf_out[i] : data_q[i];
            if (dir_q[i]) begin
                pin_oe[i]  = ~src;
                pin_out[i] = 1'b0;
            end else begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = src;
            end
        end
    end

endmodule

// File: rtl/gpio_side_fx.sv
module gpio_side_fx #(
    parameter int W        = 8,
    parameter int INT0_BIT = 2,
    parameter int INT1_BIT = 4,
    parameter int HOLD_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fsel_wr,
    input  logic [W-1:0] wbe,
    input  logic [W-1:0] fsel_q,
    input  logic [W-1:0] pins_sync,
    output logic         int0_set,
    output logic         int1_set,
    output logic         hold_req_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int0_set <= 1'b0;
            int1_set <= 1'b0;
        end else begin
            int0_set <= fsel_wr && wbe[INT0_BIT];
            int1_set <= fsel_wr && wbe[INT1_BIT];
        end
    end

    assign hold_req_n = fsel_q[HOLD_BIT] ? pins_sync[HOLD_BIT] : 1'b1;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int         W           = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         INT0_BIT    = 2,
    parameter int         INT1_BIT    = 4,
    parameter int         HOLD_BIT    = 5,
    parameter logic [7:0] DATA_RST    = 8'hFF,
    parameter logic [7:0] DIR_RST     = 8'hFF,
    parameter logic [7:0] FSEL_RST    = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wbe,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] sf_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_pu,
    output logic         int0_set,
    output logic         int1_set,
    output logic         hold_req_n
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] fsel_q;
    logic [W-1:0] pins_sync;
    logic         fsel_wr;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
    );

    gpio_regfile #(.W(W), .DATA_RST(DATA_RST), .DIR_RST(DIR_RST), .FSEL_RST(FSEL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .wbe(wbe),
        .pins_sync(pins_sync), .data_q(data_q), .dir_q(dir_q), .fsel_q(fsel_q),
        .rdata(rdata), .fsel_wr(fsel_wr)
    );

    gpio_pullup_fsm #(.W(W)) u_pu (
        .clk(clk), .rst_n(rst_n), .fsel_wr(fsel_wr), .pu_en(pin_pu)
    );

    gpio_pin_drive #(.W(W)) u_drive (
        .data_q(data_q), .dir_q(dir_q), .fsel_q(fsel_q), .sf_out(sf_out),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    gpio_side_fx #(.W(W), .INT0_BIT(INT0_BIT), .INT1_BIT(INT1_BIT), .HOLD_BIT(HOLD_BIT)) u_fx (
        .clk(clk), .rst_n(rst_n), .fsel_wr(fsel_wr), .wbe(wbe), .fsel_q(fsel_q),
        .pins_sync(pins_sync), .int0_set(int0_set), .int1_set(int1_set),
        .hold_req_n(hold_req_n)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W        = 8,
    parameter int INT0_BIT = 2,
    parameter int INT1_BIT = 4,
    parameter int HOLD_BIT = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wbe,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] fsel_q,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_pu,
    input logic         int0_set,
    input logic         int1_set,
    input logic         hold_req_n
);

    logic fsel_write;
    assign fsel_write = wr_en && (reg_sel_e'(addr) == REG_FSEL);

    // R2
    pu_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_write |=> (pin_pu == '0));

    // R2
    pu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu == '0) |=> (pin_pu == '0));

    // R3
    pu_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu == '0) || (pin_pu == '1));

    // R4
    pushpull_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~pin_oe) == '0));

    // R5
    opendrain_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & pin_oe & pin_out) == '0));

    // R8
    int0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_write && wbe[INT0_BIT]) |=> int0_set);

    // R8
    int0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsel_write && wbe[INT0_BIT]) |=> !int0_set);

    // R8
    int1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_write && wbe[INT1_BIT]) |=> int1_set);

    // R8
    int1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsel_write && wbe[INT1_BIT]) |=> !int1_set);

    // R9
    hold_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fsel_q[HOLD_BIT] |-> hold_req_n);

endmodule

bind gpio_port_ctrl gpio_port_chk #(
    .W(W), .INT0_BIT(INT0_BIT), .INT1_BIT(INT1_BIT), .HOLD_BIT(HOLD_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbe(wbe),
    .dir_q(dir_q), .fsel_q(fsel_q), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pu(pin_pu), .int0_set(int0_set), .int1_set(int1_set),
    .hold_req_n(hold_req_n)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] wbe = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] sf_out = 8'h00;
    logic [7:0] pin_oe, pin_out, pin_pu;
    logic       int0_set, int1_set, hold_req_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wbe(wbe), .rdata(rdata), .pin_in(pin_in), .sf_out(sf_out),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .int0_set(int0_set), .int1_set(int1_set), .hold_req_n(hold_req_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive on a falling edge, held across one rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wbe = m;
        @(negedge clk);
        wr_en = 1'b0; wbe = 8'h00;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        rd(2'd0, v); chk("R1", "data reset", v, 8'hFF);
        rd(2'd1, v); chk("R1", "dir reset", v, 8'hFF);
        rd(2'd2, v); chk("R1", "fsel reset", v, 8'h00);
        chk("R1", "pu reset", pin_pu, 8'hFF);
        chk("R1", "oe reset", pin_oe, 8'h00);
    endtask

    task automatic t_example_sequence();
        do_reset();
        wr(2'd1, 8'h1F, 8'hFF);
        chk("R3", "pu after dir write", pin_pu, 8'hFF);
        chk("R4", "oe after dir write", pin_oe, 8'hE0);
        chk("R4", "out after dir write", pin_out, 8'hE0);
        wr(2'd2, 8'h00, 8'hFF);
        chk("R2", "pu after fsel write", pin_pu, 8'h00);
        chk("R8", "int0 after full-mask fsel write", {7'd0, int0_set}, 8'h01);
        chk("R8", "int1 after full-mask fsel write", {7'd0, int1_set}, 8'h01);
        @(negedge clk); #1;
        chk("R8", "int0 single cycle", {7'd0, int0_set}, 8'h00);
        wr(2'd0, 8'h93, 8'hFF);
        chk("R11", "example oe", pin_oe, 8'hEC);
        chk("R11", "example out", pin_out, 8'h80);
        chk("R5", "open-drain low bits oe", pin_oe & 8'h1F, 8'h0C);
        chk("R3", "pu after data write", pin_pu, 8'h00);
    endtask

    task automatic t_silent_release();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h00, 8'hFF);
        chk("R3", "pu after data write", pin_pu, 8'hFF);
        wr(2'd2, 8'hFF, 8'h00);
        chk("R2", "pu after empty-mask fsel write", pin_pu, 8'h00);
        chk("R8", "no int0 on empty mask", {7'd0, int0_set}, 8'h00);
        chk("R8", "no int1 on empty mask", {7'd0, int1_set}, 8'h00);
        rd(2'd2, v); chk("R7", "fsel unchanged by empty mask", v, 8'h00);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'h00, 8'hFF);
        #1; chk("R2", "pu stays released", pin_pu, 8'h00);
    endtask

    task automatic t_mask_and_sf();
        logic [7:0] v;
        do_reset();
        wr(2'd2, 8'h00, 8'h00);
        wr(2'd1, 8'h00, 8'h0F);
        rd(2'd1, v); chk("R7", "dir low nibble masked", v, 8'hF0);
        wr(2'd0, 8'h5A, 8'h3C);
        rd(2'd0, v); chk("R7", "data masked", v, 8'hDB);
        sf_out = 8'hA5;
        wr(2'd2, 8'hFF, 8'h03);
        chk("R8", "no int on fsel bits 0-1", {6'd0, int1_set, int0_set}, 8'h00);
        // pins 1:0 push-pull from sf (1,0 -> bit0=1,bit1=0); 3:2 push-pull data (1,0)
        #1;
        chk("R6", "sf selected out", pin_out & 8'h0F, 8'h09);
        chk("R4", "push-pull oe", pin_oe & 8'h0F, 8'h0F);
        wr(2'd2, 8'hFF, 8'h80);
        // pin7 open-drain with sf bit7=1 -> hi-Z
        chk("R5", "od sf high hi-Z", pin_oe & 8'h80, 8'h00);
        sf_out = 8'h25; #1;
        chk("R5", "od sf low drives", {pin_oe[7], pin_out[7]} == 2'b10 ? 8'h01 : 8'h00, 8'h01);
        wr(2'd2, 8'h00, 8'h10);
        chk("R8", "int1 on bit4 write", {7'd0, int1_set}, 8'h01);
        chk("R8", "no int0 on bit4 write", {7'd0, int0_set}, 8'h00);
        wr(2'd2, 8'h00, 8'h04);
        chk("R8", "int0 on bit2 write", {7'd0, int0_set}, 8'h01);
        chk("R8", "no int1 on bit2 write", {7'd0, int1_set}, 8'h00);
        sf_out = 8'h00;
    endtask

    task automatic t_input_and_hold();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        pin_in = 8'h00;
        @(negedge clk);
        chk("R9", "hold inactive in io mode", {7'd0, hold_req_n}, 8'h01);
        rd(2'd3, v); chk("R10", "pins after one edge", v, 8'hFF);
        @(negedge clk);
        rd(2'd3, v); chk("R10", "pins after two edges", v, 8'h00);
        wr(2'd3, 8'hFF, 8'hFF);
        rd(2'd0, v); chk("R10", "data unchanged by pin-addr write", v, 8'hFF);
        rd(2'd1, v); chk("R10", "dir unchanged by pin-addr write", v, 8'hFF);
        rd(2'd2, v); chk("R10", "fsel unchanged by pin-addr write", v, 8'h00);
        chk("R10", "pu unchanged by pin-addr write", pin_pu, 8'hFF);
        wr(2'd2, 8'h20, 8'h20);
        chk("R9", "hold follows low pin", {7'd0, hold_req_n}, 8'h00);
        pin_in = 8'h20;
        @(negedge clk); #1;
        chk("R9", "hold still synchronizing", {7'd0, hold_req_n}, 8'h00);
        @(negedge clk); #1;
        chk("R9", "hold follows high pin", {7'd0, hold_req_n}, 8'h01);
        wr(2'd1, 8'h00, 8'hFF);
        pin_in = 8'h6C;
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk("R10", "pins under push-pull", v, 8'h6C);
        pin_in = 8'hFF;
    endtask

    initial begin
        t_reset_state();
        t_example_sequence();
        t_silent_release();
        t_mask_and_sf();
        t_input_and_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule